// File: doc/BRIEF.md
# Resumable Load/Store-Multiple Sequencer

This block turns one load/store-multiple operation into single-word bus transfers. The operation is given by a 16-bit register mask, a base address and a direction flag. Transfers go out one at a time in ascending register order. Each one is offered on a valid/ready request channel and is finished by a completion pulse. Push, pop and multi-register floating-point transfers use the same engine: only the mask and the direction differ.

When an interrupt is accepted, the core holds the suspend input high. The sequencer lets the transfer already on the bus finish, then stops. It reports a 4-bit progress index, which is the next register still to move. The core saves that index in the stacked status word. When the handler returns, the core starts the sequencer again with that index. Registers below the index are skipped. The addresses are rebuilt from the mask, so the remaining transfers land at the same places they would have reached without the interruption.

Top module: `lsm_seq`

## Requirements
- R1: One transfer is requested for each set mask bit at or above the start index, strictly in ascending register order. `req_reg_o` carries the register number and `req_write_o` carries the direction latched at start (1 = store, 0 = load).
- R2: The address of a transfer for register r is the base plus four times the number of set mask bits below r.
- R3: Once `req_valid_o` is raised, it stays high with unchanged address and register until `req_ready_i` is seen. No new request is raised while a completion is outstanding.
- R4: If `suspend_i` is high in the cycle a non-final completion arrives, no further request is issued. `susp_o` pulses for one cycle on the next cycle, `busy_o` drops, and `progress_o` holds the next set register index.
- R5: A start with a nonzero `progress_i` skips every mask bit below that index and keeps the R2 addresses. Repeated suspend/resume cycles therefore move each register exactly once.
- R6: A start with `progress_i` equal to zero behaves as a fresh start over the whole mask.
- R7: `done_o` pulses for one cycle, on the cycle after the final completion, with `progress_o` equal to 0. A suspend request during the final transfer yields `done_o`, not `susp_o`. The two pulses never coincide.
- R8: A mask with no set bit at or above the start index produces `done_o` on the cycle after the start, with no bus request.
- R9: `busy_o` is high from the cycle after an accepted start until the done or suspend pulse. A `start_i` while busy is ignored, and so is `suspend_i` outside a completion cycle.
- R10: After reset the block is idle: `busy_o`, `req_valid_o`, `done_o` and `susp_o` are 0, and `progress_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or resume pulse, taken only when idle |
| list_i | input | NREG | Register mask |
| base_i | input | AW | Base address |
| write_i | input | 1 | Direction: 1 store, 0 load |
| progress_i | input | IW | Start index (0 = fresh, else saved progress) |
| suspend_i | input | 1 | Request to stop after the current transfer |
| req_valid_o | output | 1 | Transfer request valid |
| req_ready_i | input | 1 | Transfer request accepted |
| req_addr_o | output | AW | Transfer address |
| req_write_o | output | 1 | Transfer direction |
| req_reg_o | output | IW | Register number of the transfer |
| rsp_valid_i | input | 1 | Completion of the accepted transfer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Whole mask finished (pulse) |
| susp_o | output | 1 | Sequence stopped early (pulse) |
| progress_o | output | IW | Next register to transfer |

## Verification
The bench keeps the default build: a 16-entry mask and 32-bit addresses. With these values the all-ones mask, the top register index 15 and start indices beyond the last set bit can all be reached. The request-ready pattern is pseudo-random and the completion delay varies. The bench also runs a loop that suspends after every transfer and resumes from the exported index until the mask is finished. This exercises every resume point of a sparse mask against the address rule.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } lsm_state_e;
endpackage

// File: rtl/lsm_pick.sv
// Lowest set mask bit at or above from_i.
module lsm_pick #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] list_i,
  input  logic [IW:0]     from_i,
  output logic            found_o,
  output logic [IW-1:0]   idx_o
);
  logic [NREG-1:0] cand;

  for (genvar k = 0; k < NREG; k++) begin : g_cand
    assign cand[k] = list_i[k] && ((IW+1)'(k) >= from_i);
  end

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = NREG - 1; k >= 0; k--) begin
      if (cand[k]) begin
        found_o = 1'b1;
        idx_o   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/lsm_offs.sv
// Address = base + 4 * (set bits below idx).
module lsm_offs #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] list_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [AW-1:0]   base_i,
  output logic [AW-1:0]   addr_o
);
  logic [IW:0] cnt;

  always_comb begin
    cnt = '0;
    for (int k = 0; k < NREG; k++) begin
      if (list_i[k] && (IW'(k) < idx_i)) cnt = cnt + 1'b1;
    end
  end

  assign addr_o = base_i + AW'({cnt, 2'b00});
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NREG-1:0] list_i,
  input  logic [AW-1:0]   base_i,
  input  logic            write_i,
  input  logic [IW-1:0]   progress_i,
  input  logic            suspend_i,
  output logic            req_valid_o,
  input  logic            req_ready_i,
  output logic [AW-1:0]   req_addr_o,
  output logic            req_write_o,
  output logic [IW-1:0]   req_reg_o,
  input  logic            rsp_valid_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            susp_o,
  output logic [IW-1:0]   progress_o
);
  lsm_state_e      state_q;
  logic [NREG-1:0] list_q;
  logic [AW-1:0]   base_q;
  logic            wr_q;
  logic [IW-1:0]   idx_q;
  logic            done_q, susp_q;

  logic            st_found, nx_found;
  logic [IW-1:0]   st_idx, nx_idx;

  lsm_pick #(.NREG(NREG)) u_pick_start (
    .list_i  (list_i),
    .from_i  ({1'b0, progress_i}),
    .found_o (st_found),
    .idx_o   (st_idx)
  );

  lsm_pick #(.NREG(NREG)) u_pick_next (
    .list_i  (list_q),
    .from_i  ({1'b0, idx_q} + 1'b1),
    .found_o (nx_found),
    .idx_o   (nx_idx)
  );

  lsm_offs #(.NREG(NREG), .AW(AW)) u_offs (
    .list_i (list_q),
    .idx_i  (idx_q),
    .base_i (base_q),
    .addr_o (req_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      list_q  <= '0;
      base_q  <= '0;
      wr_q    <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      susp_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          list_q <= list_i;
          base_q <= base_i;
          wr_q   <= write_i;
          if (st_found) begin
            idx_q   <= st_idx;
            state_q <= ST_REQ;
          end else begin
            idx_q  <= '0;
            done_q <= 1'b1;
          end
        end
        ST_REQ: if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          if (!nx_found) begin
            // final transfer wins over a suspend request
            idx_q   <= '0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (suspend_i) begin
            idx_q   <= nx_idx;
            susp_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= nx_idx;
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_REQ);
  assign req_write_o = wr_q;
  assign req_reg_o   = idx_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign susp_o      = susp_q;
  assign progress_o  = idx_q;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int IW = $clog2(NREG)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_o,
  input logic            req_ready_i,
  input logic [AW-1:0]   req_addr_o,
  input logic [IW-1:0]   req_reg_o,
  input logic            rsp_valid_i,
  input logic            suspend_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            susp_o,
  input logic [IW-1:0]   progress_o,
  input logic [NREG-1:0] list_q
);
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_reg_o)); // R3

  AST_REG_IN_LIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> list_q[req_reg_o]); // R1

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && susp_o)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o); // R9

  AST_SUSP_AFTER_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> $past(rsp_valid_i && suspend_i) && !busy_o); // R4

  AST_SUSP_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> progress_o != '0); // R5

  AST_DONE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> progress_o == '0 && !busy_o); // R7
endmodule

bind lsm_seq lsm_seq_chk #(.NREG(NREG), .AW(AW)) u_lsm_seq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_reg_o   (req_reg_o),
  .rsp_valid_i (rsp_valid_i),
  .suspend_i   (suspend_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .susp_o      (susp_o),
  .progress_o  (progress_o),
  .list_q      (list_q)
);

// File: tb/tb_lsm_seq.sv
`timescale 1ns/1ps
module tb_lsm_seq;
  localparam int NREG = 16;
  localparam int AW   = 32;
  localparam int IW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [NREG-1:0] list_i = '0;
  logic [AW-1:0]   base_i = '0;
  logic            write_i = 1'b0;
  logic [IW-1:0]   progress_i = '0;
  logic            suspend_i = 1'b0;
  logic            req_valid_o, req_write_o, busy_o, done_o, susp_o;
  logic            req_ready_i = 1'b0;
  logic            rsp_valid_i = 1'b0;
  logic [AW-1:0]   req_addr_o;
  logic [IW-1:0]   req_reg_o, progress_o;

  always #2.5 clk = ~clk;

  lsm_seq #(.NREG(NREG), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .list_i(list_i),
    .base_i(base_i), .write_i(write_i), .progress_i(progress_i),
    .suspend_i(suspend_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_write_o(req_write_o), .req_reg_o(req_reg_o),
    .rsp_valid_i(rsp_valid_i), .busy_o(busy_o), .done_o(done_o),
    .susp_o(susp_o), .progress_o(progress_o)
  );

  int n_chk = 0, n_fail = 0;
  int n_hs = 0, n_rsp = 0;
  bit seen_done, seen_susp;

  // reference model
  bit              m_busy, m_wait, m_done, m_susp, m_wr;
  int              m_q[$];
  int              m_prog;
  logic [NREG-1:0] m_list;
  logic [AW-1:0]   m_base;
  bit              pend;
  int              dly;
  logic [7:0]      lfsr = 8'hA5;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(int r);
    int c = 0;
    for (int k = 0; k < r; k++) if (m_list[k]) c++;
    return m_base + AW'(4 * c);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      m_done = 0;
      m_susp = 0;
      if (!m_busy) begin
        if (start_i) begin
          m_list = list_i; m_base = base_i; m_wr = write_i;
          m_q.delete();
          for (int k = int'(progress_i); k < NREG; k++) if (list_i[k]) m_q.push_back(k);
          if (m_q.size() == 0) begin m_done = 1; m_prog = 0; end
          else begin m_busy = 1; m_wait = 0; end
        end
      end else if (!m_wait) begin
        if (req_ready_i) begin m_wait = 1; pend = 1; dly = int'(lfsr[1:0]); n_hs++; end
      end else if (rsp_valid_i) begin
        pend = 0;
        n_rsp++;
        void'(m_q.pop_front());
        if (m_q.size() == 0) begin m_done = 1; m_busy = 0; m_prog = 0; end
        else if (suspend_i) begin m_susp = 1; m_busy = 0; m_prog = m_q[0]; end
        else m_wait = 0;
      end
      #1;
      chk("R9", "busy", busy_o, m_busy);
      chk("R3", "req_valid", req_valid_o, m_busy && !m_wait);
      if (m_busy && !m_wait) begin
        chk("R1", "req_reg", req_reg_o, m_q[0]);
        chk("R1", "req_write", req_write_o, m_wr);
        chk("R2", "req_addr", req_addr_o, exp_addr(m_q[0]));
      end
      chk("R7", "done", done_o, m_done);
      chk("R4", "susp", susp_o, m_susp);
      chk("R5", "progress", progress_o, m_busy ? m_q[0] : m_prog);
      if (done_o) seen_done = 1;
      if (susp_o) seen_susp = 1;
    end
  end

  // responder
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    req_ready_i = lfsr[0] | lfsr[2];
    if (pend && dly > 0) begin dly--; rsp_valid_i = 1'b0; end
    else rsp_valid_i = pend;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // susp_at: -1 never, else raise suspend_i that many cycles after start
  task automatic run(logic [NREG-1:0] l, logic [AW-1:0] b, bit w, int p, int susp_at, bit glitch);
    bit fin = 0;
    seen_done = 0; seen_susp = 0;
    @(negedge clk);
    list_i = l; base_i = b; write_i = w; progress_i = IW'(p);
    suspend_i = (susp_at == 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 1; cyc < 3000 && !fin; cyc++) begin
      if (seen_done || seen_susp) fin = 1;
      else begin
        if (cyc == susp_at) suspend_i = 1'b1;
        if (glitch && cyc == 3) begin
          start_i = 1'b1; list_i = ~l; progress_i = '0; base_i = b + 32'h100;
        end else start_i = 1'b0;
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    suspend_i = 1'b0;
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  endtask

  initial begin
    int h0, ns;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "busy", busy_o, 0);
    chk("R10", "req_valid", req_valid_o, 0);
    chk("R10", "done", done_o, 0);
    chk("R10", "susp", susp_o, 0);
    chk("R10", "progress", progress_o, 0);
    rst_n = 1'b1;

    // R1 R2 full mask, store
    h0 = n_hs; run(16'hFFFF, 32'h0000_1000, 1, 0, -1, 0);
    chk("R7", "done seen", seen_done, 1);
    chk("R1", "transfers full", n_hs - h0, 16);

    // sparse load
    h0 = n_hs; run(16'h8421, 32'h2000_0040, 0, 0, -1, 0);
    chk("R1", "transfers sparse", n_hs - h0, 4);

    // R8 empty mask
    h0 = n_hs; run(16'h0000, 32'h300, 0, 0, -1, 0);
    chk("R8", "empty done", seen_done, 1);
    chk("R8", "empty transfers", n_hs - h0, 0);

    // R8 start index beyond every set bit
    h0 = n_hs; run(16'h000F, 32'h400, 0, 8, -1, 0);
    chk("R8", "beyond done", seen_done, 1);
    chk("R8", "beyond transfers", n_hs - h0, 0);

    // R4 R5 suspend after every transfer, resume from saved index
    h0 = n_hs; ns = 0;
    run(16'hA5F0, 32'h8000_0000, 1, 0, 0, 0);
    while (seen_susp) begin
      ns++;
      run(16'hA5F0, 32'h8000_0000, 1, int'(progress_o), 0, 0);
    end
    chk("R5", "resumed transfers", n_hs - h0, 8);
    chk("R4", "suspend count", ns, 7);
    chk("R7", "final done", seen_done, 1);

    // R4 suspend raised mid-run
    h0 = n_hs;
    run(16'h3C3C, 32'h500, 0, 0, 6, 0);
    chk("R4", "mid suspend seen", seen_susp, 1);
    if (seen_susp) run(16'h3C3C, 32'h500, 0, int'(progress_o), -1, 0);
    chk("R5", "mid resume total", n_hs - h0, 8);

    // R6 zero start index after a suspension elsewhere
    h0 = n_hs; run(16'h0F0F, 32'h600, 1, 0, -1, 0);
    chk("R6", "fresh transfers", n_hs - h0, 8);

    // R7 suspend during only transfer gives done
    run(16'h0040, 32'h700, 0, 0, 0, 0);
    chk("R7", "single done", seen_done, 1);
    chk("R7", "single no susp", seen_susp, 0);

    // R9 start while busy ignored
    h0 = n_hs; run(16'h00FF, 32'h900, 1, 0, -1, 1);
    chk("R9", "ignored restart", n_hs - h0, 8);

    repeat (5) @(negedge clk);
    summary();
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end
endmodule